// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit carries out the instruction group reached through the prefix byte of an 8-bit processor. It works on one operand at a time. A 2-bit group field selects one of four groups: rotate/shift, bit test, bit clear and bit set. A 3-bit field then chooses either the rotate/shift variant or the bit index. The unit returns the new operand value, the new flag nibble and a write-back enable. It also reports whether the operand came from memory and how many machine cycles the instruction costs.

Register-file selection and memory access stay outside the block. The caller passes in the source index only so the unit can cost the instruction. The caller also flags the four unprefixed accumulator rotates, which differ from the prefixed forms only in the zero flag and the cycle count. The computation itself is combinational. One output register stage places each result exactly one clock after its request.

Top module: `gbx_pfx_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid`, `wr_en`, `mem_operand`, `result`, `flags_out` and `cycles` are all cleared, even if `in_valid` is high.
- R2: A request accepted with `in_valid` high produces `out_valid` high on the next rising edge, and the outputs then describe that request. A cycle without a request produces `out_valid` low.
- R3: With `grp`=0 the rotates are chosen by `sel`. Values 0 and 1 rotate left and right and feed the outgoing bit back in. Values 2 and 3 rotate left and right through the carry, so the old carry (`flags_in[0]`) enters the vacated end.
- R4: With `grp`=0 the shifts are chosen by `sel`. Value 4 is a left shift that fills with zero. Value 5 is a right shift that keeps bit 7. Value 7 is a right shift that clears bit 7. Values 3, 5 and 7 take the carry from bit 0, and values 0, 2 and 4 take it from bit 7.
- R5: With `grp`=0 and `sel`=6 the two nibbles of the operand swap places, and the carry is cleared.
- R6: Every `grp`=0 operation clears subtract (`flags_out[2]`) and half-carry (`flags_out[1]`), sets zero (`flags_out[3]`) when the result is 0x00, and writes the result back.
- R7: When `acc_form` is high with `grp`=0 and `sel` from 0 to 3, the zero flag is forced to 0 and the cost is 1 cycle. In every other combination `acc_form` has no effect.
- R8: With `grp`=1 the unit tests bit `sel`. Zero is set when that bit is 0, half-carry is set, subtract is cleared and carry keeps `flags_in[0]`. `wr_en` stays low and `result` equals the operand.
- R9: With `grp`=2 the unit clears bit `sel`, and with `grp`=3 it sets bit `sel`. In both cases `flags_out` equals `flags_in` and `wr_en` is high.
- R10: With `src_idx`=6 the operand counts as memory: `mem_operand` is high and `cycles` is 4. Any other index costs 2 cycles with `mem_operand` low. The accumulator form of R7 overrides both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| grp | input | 2 | Group: 0 rotate/shift, 1 test, 2 clear, 3 set |
| sel | input | 3 | Rotate/shift variant or bit index |
| src_idx | input | 3 | Operand source index, 6 means memory |
| acc_form | input | 1 | Unprefixed accumulator rotate |
| operand | input | 8 | Operand value |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| out_valid | output | 1 | Result present |
| result | output | 8 | New operand value |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| wr_en | output | 1 | Result must be written back |
| mem_operand | output | 1 | Operand was in memory |
| cycles | output | 3 | Machine-cycle cost |

## Verification
Two functions can act on one request: the accumulator form and the memory-source costing. They collide when `acc_form` is raised together with `src_idx`=6 on a rotate. The bench sends that combination and expects the accumulator rules to win, which means a cost of 1 and `mem_operand` low. It also sends `acc_form` with a bit test from memory and expects the memory rules to apply unchanged.

// File: rtl/gbx_pfx_pkg.sv
// Shared encodings for the prefixed bit-manipulation unit.
// Assumes flags are packed as {Z,N,H,C}, with C in bit 0.
package gbx_pfx_pkg;
    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SETB  = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC  = 3'd0,
        SH_RRC  = 3'd1,
        SH_RL   = 3'd2,
        SH_RR   = 3'd3,
        SH_SLA  = 3'd4,
        SH_SRA  = 3'd5,
        SH_SWAP = 3'd6,
        SH_SRL  = 3'd7
    } sh_e;

    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;
    localparam int FLAG_W = 4;
    localparam int CYC_W = 3;
    localparam logic [2:0] MEM_IDX = 3'd6;
endpackage

// File: rtl/gbx_pfx_shifter.sv
// Rotate/shift/swap datapath.
// Purely combinational. cin is the incoming carry, and cout is the bit
// shifted out (0 for a swap).
module gbx_pfx_shifter
    import gbx_pfx_pkg::*;
#(
    parameter int W = 8
) (
    input  sh_e          op,
    input  logic [W-1:0] val,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HALF = W / 2;

    // Select the variant's result and the carry it produces.
    always_comb begin
        res  = val;
        cout = 1'b0;
        unique case (op)
            SH_RLC:  begin res = {val[W-2:0], val[W-1]}; cout = val[W-1]; end
            SH_RRC:  begin res = {val[0], val[W-1:1]};   cout = val[0];   end
            SH_RL:   begin res = {val[W-2:0], cin};      cout = val[W-1]; end
            SH_RR:   begin res = {cin, val[W-1:1]};      cout = val[0];   end
            SH_SLA:  begin res = {val[W-2:0], 1'b0};     cout = val[W-1]; end
            SH_SRA:  begin res = {val[W-1], val[W-1:1]}; cout = val[0];   end
            SH_SWAP: begin res = {val[HALF-1:0], val[W-1:HALF]}; cout = 1'b0; end
            SH_SRL:  begin res = {1'b0, val[W-1:1]};     cout = val[0];   end
            default: begin res = val; cout = 1'b0; end
        endcase
    end

    // The swap leaves no carry behind (R5).
    always_comb begin
        if (op == SH_SWAP) assert_swap_nocarry_R5: assert (cout == 1'b0);
    end
endmodule

// File: rtl/gbx_pfx_bitop.sv
// Single-bit test/clear/set datapath.
// Purely combinational. idx names the bit. Groups other than clear and
// set pass the value through unchanged.
module gbx_pfx_bitop
    import gbx_pfx_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  grp_e          grp,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  val,
    output logic [W-1:0]  res,
    output logic          tested
);
    // One slice per bit, each deciding its own new value.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        assign hit = (idx == IW'(i));
        always_comb begin
            unique case (grp)
                GRP_CLR:  res[i] = hit ? 1'b0 : val[i];
                GRP_SETB: res[i] = hit ? 1'b1 : val[i];
                default:  res[i] = val[i];
            endcase
        end
    end

    // Pick out the bit under test.
    assign tested = val[idx];
endmodule

// File: rtl/gbx_pfx_unit.sv
// Top of the prefixed bit-manipulation unit.
// Builds the flags, write enable and cycle cost around the two datapaths
// and registers everything once. Assumes W >= 8, so the low three sel
// bits pick the rotate/shift variant.
module gbx_pfx_unit
    import gbx_pfx_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        grp,
    input  logic [IW-1:0]     sel,
    input  logic [2:0]        src_idx,
    input  logic              acc_form,
    input  logic [W-1:0]      operand,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              wr_en,
    output logic              mem_operand,
    output logic [CYC_W-1:0]  cycles
);
    localparam logic [CYC_W-1:0] CYC_ACC = CYC_W'(1);
    localparam logic [CYC_W-1:0] CYC_REG = CYC_W'(2);
    localparam logic [CYC_W-1:0] CYC_MEM = CYC_W'(4);

    grp_e              grp_t;
    sh_e               sh_op;
    logic [W-1:0]      sh_res;
    logic              sh_cout;
    logic [W-1:0]      bo_res;
    logic              bo_bit;
    logic              acc_eff;
    logic              from_mem;
    logic [W-1:0]      nx_res;
    logic [FLAG_W-1:0] nx_flags;
    logic              nx_wr;
    logic [CYC_W-1:0]  nx_cyc;

    assign grp_t = grp_e'(grp);
    assign sh_op = sh_e'(sel[2:0]);

    gbx_pfx_shifter #(.W(W)) u_shift (
        .op   (sh_op),
        .val  (operand),
        .cin  (flags_in[FC]),
        .res  (sh_res),
        .cout (sh_cout)
    );

    gbx_pfx_bitop #(.W(W), .IW(IW)) u_bits (
        .grp    (grp_t),
        .idx    (sel),
        .val    (operand),
        .res    (bo_res),
        .tested (bo_bit)
    );

    // Decide whether the accumulator form applies and where the operand lives.
    always_comb begin
        acc_eff  = acc_form && (grp_t == GRP_SHIFT) && !sel[2];
        from_mem = !acc_eff && (src_idx == MEM_IDX);
        nx_cyc   = acc_eff ? CYC_ACC : (from_mem ? CYC_MEM : CYC_REG);
    end

    // Build the result, the flags and the write enable for each group.
    always_comb begin
        nx_res   = operand;
        nx_flags = flags_in;
        nx_wr    = 1'b1;
        unique case (grp_t)
            GRP_SHIFT: begin
                nx_res       = sh_res;
                nx_flags[FZ] = acc_eff ? 1'b0 : (sh_res == '0);
                nx_flags[FN] = 1'b0;
                nx_flags[FH] = 1'b0;
                nx_flags[FC] = sh_cout;
            end
            GRP_TEST: begin
                nx_wr        = 1'b0;
                nx_flags[FZ] = !bo_bit;
                nx_flags[FN] = 1'b0;
                nx_flags[FH] = 1'b1;
            end
            default: nx_res = bo_res;
        endcase
    end

    // Output stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            flags_out   <= '0;
            wr_en       <= 1'b0;
            mem_operand <= 1'b0;
            cycles      <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && nx_wr;
            if (in_valid) begin
                result      <= nx_res;
                flags_out   <= nx_flags;
                mem_operand <= from_mem;
                cycles      <= nx_cyc;
            end
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_shift_clears_nh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(grp) == 2'd0) |-> (flags_out[FN] == 1'b0 && flags_out[FH] == 1'b0 && wr_en));
    assert_test_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(grp) == 2'd1) |->
        (!wr_en && result == $past(operand) && flags_out[FC] == $past(flags_in[FC])));
    assert_setclr_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(grp[1])) |-> (flags_out == $past(flags_in) && wr_en));
    assert_mem_cost_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mem_operand == (cycles == CYC_MEM)));
endmodule

// File: tb/sim_gbx_pfx_unit.sv
module sim_gbx_pfx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] grp = '0;
    logic [2:0] sel = '0;
    logic [2:0] src_idx = '0;
    logic       acc_form = 1'b0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic       out_valid;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       wr_en;
    logic       mem_operand;
    logic [2:0] cycles;

    always #2.5 clk = ~clk;

    gbx_pfx_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grp(grp), .sel(sel),
        .src_idx(src_idx), .acc_form(acc_form), .operand(operand),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .flags_out(flags_out), .wr_en(wr_en), .mem_operand(mem_operand),
        .cycles(cycles)
    );

    typedef struct {
        logic [16:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Expected packing: {result[7:0], flags[3:0], wr, mem, cycles[2:0]}
    function automatic logic [16:0] model(input logic [1:0] g, input logic [2:0] s,
            input logic [2:0] idx, input logic acc, input logic [7:0] v, input logic [3:0] fi);
        logic [8:0] w;
        logic [7:0] r;
        logic [3:0] f;
        logic wr, acc_on, mem;
        logic [2:0] cyc;
        r = v; f = fi; wr = 1'b1;
        acc_on = acc && (g == 2'd0) && (s < 3'd4);
        if (g == 2'd0) begin
            case (s)
                3'd0: w = {v, v[7]};
                3'd1: w = {v[0], v[0], v[7:1]};
                3'd2: w = {v, fi[0]};
                3'd3: w = {v[0], fi[0], v[7:1]};
                3'd4: w = {v, 1'b0};
                3'd5: w = {v[0], v[7], v[7:1]};
                3'd6: w = {1'b0, v[3:0], v[7:4]};
                default: w = {v[0], 1'b0, v[7:1]};
            endcase
            r = w[7:0];
            if (s == 3'd0 || s == 3'd2 || s == 3'd4) begin
                r = w[7:0];
                f[0] = w[8];
            end else begin
                f[0] = w[8];
            end
            f[3] = acc_on ? 1'b0 : (r == 8'h00);
            f[2] = 1'b0; f[1] = 1'b0;
        end else if (g == 2'd1) begin
            wr = 1'b0;
            f = {~v[s], 1'b0, 1'b1, fi[0]};
        end else if (g == 2'd2) begin
            r = v & ~(8'h01 << s);
        end else begin
            r = v | (8'h01 << s);
        end
        mem = !acc_on && (idx == 3'd6);
        cyc = acc_on ? 3'd1 : (mem ? 3'd4 : 3'd2);
        return {r, f, wr, mem, cyc};
    endfunction

    task automatic send(input logic [1:0] g, input logic [2:0] s, input logic [2:0] idx,
            input logic acc, input logic [7:0] v, input logic [3:0] fi, input string tag);
        item_t it;
        @(negedge clk);
        grp = g; sel = s; src_idx = idx; acc_form = acc; operand = v; flags_in = fi;
        in_valid = 1'b1;
        it.exp = model(g, s, idx, acc, v, fi);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic check(input logic [16:0] act, input logic [16:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each produced result against the scoreboard head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                if (q.size() == 0) begin
                    check(17'h1ffff, 17'h0, "R2 unexpected output");
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check({result, flags_out, wr_en, mem_operand, cycles}, it.exp, it.tag);
                end
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        operand = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check({out_valid, wr_en, mem_operand, result, flags_out, cycles}, '0, "R1 reset state");
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        send(2'd0, 3'd0, 3'd0, 1'b0, 8'h85, 4'h0, "R3 RLC");
        send(2'd0, 3'd1, 3'd1, 1'b0, 8'h01, 4'h0, "R3 RRC");
        send(2'd0, 3'd2, 3'd2, 1'b0, 8'h80, 4'h0, "R3 RL zero");
        send(2'd0, 3'd3, 3'd3, 1'b0, 8'h01, 4'h1, "R3 RR carry in");
        send(2'd0, 3'd4, 3'd0, 1'b0, 8'hFF, 4'h0, "R4 SLA");
        send(2'd0, 3'd5, 3'd0, 1'b0, 8'h81, 4'h0, "R4 SRA");
        send(2'd0, 3'd7, 3'd0, 1'b0, 8'h81, 4'h0, "R4 SRL");
        send(2'd0, 3'd7, 3'd0, 1'b0, 8'h01, 4'h6, "R6 SRL zero clears NH");
        send(2'd0, 3'd6, 3'd0, 1'b0, 8'hA5, 4'h7, "R5 SWAP");
        send(2'd0, 3'd6, 3'd0, 1'b0, 8'h00, 4'h1, "R5 SWAP zero");
        send(2'd0, 3'd2, 3'd7, 1'b1, 8'h80, 4'h0, "R7 acc RL forces Z");
        send(2'd0, 3'd0, 3'd6, 1'b1, 8'h85, 4'h0, "R7 acc wins over memory");
        send(2'd0, 3'd5, 3'd0, 1'b1, 8'h00, 4'h0, "R7 acc ignored on SRA");
        send(2'd1, 3'd7, 3'd6, 1'b1, 8'h7F, 4'h1, "R8 BIT7 clear, acc ignored");
        send(2'd1, 3'd0, 3'd2, 1'b0, 8'h01, 4'hC, "R8 BIT0 set");
        send(2'd2, 3'd3, 3'd4, 1'b0, 8'hFF, 4'hA, "R9 RES3");
        send(2'd3, 3'd0, 3'd6, 1'b0, 8'h00, 4'h5, "R9 SET0 R10 memory");
        send(2'd3, 3'd7, 3'd5, 1'b0, 8'h80, 4'h0, "R10 register cost");
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({27'd0, out_valid}, 28'd0, "R2 idle");
        check({28'(q.size())}, 28'd0, "R2 all results seen");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule